// File: doc/BRIEF.md
# Tape Frame Packer and Write-Check Comparator

This block sits between a word-wide memory side and a byte-wide tape side. For a write it takes 16-bit memory words and sends each one to the tape as two 8-bit frames. For a read it collects pairs of frames from the tape, builds a word from each pair and presents that word with a strobe that stays high until the memory side acknowledges it. In write-check mode it builds tape words in the same way. It then takes the matching memory word through the memory handshake and compares the two bit by bit. Any difference sets a sticky error flag.

A command starts with a one-cycle `cmd_start` and a 3-bit mode: 0 write, 1 read forward, 2 read reverse, 3 check forward, 4 check reverse. Codes 5 to 7 are not used. Forward tape motion puts the first frame of a pair in the low byte. Reverse motion puts it in the high byte. A read or check ends when the tape side reports an inter-record gap. A write ends after the word marked last. In both cases the block pulses `end_of_block` for one cycle and then goes back to idle.

The controller is one state machine with these states:
- IDLE: waits for a command.
- FETCH: takes a memory word for a write.
- EMIT_LO: sends the first frame.
- EMIT_HI: sends the second frame.
- TAKE_A: waits for the first frame of a pair.
- TAKE_B: waits for the second frame of a pair.
- DELIVER: holds the strobe.
- COMPARE: takes the memory word for a check.
- ENDBLK: end-of-block pulse.

The transitions are:
- IDLE goes to FETCH on a write start.
- IDLE goes to TAKE_A on a read or check start.
- FETCH goes to EMIT_LO on a memory handshake.
- EMIT_LO goes to EMIT_HI on `tx_ready`.
- EMIT_HI goes back to FETCH on `tx_ready`, or to ENDBLK if the word was marked last.
- TAKE_A goes to TAKE_B on a frame.
- TAKE_A goes to ENDBLK on a gap.
- TAKE_B goes to DELIVER (read) or COMPARE (check) on a frame.
- TAKE_B also goes to DELIVER or COMPARE on a gap, with zero fill and the end of the record marked as pending.
- DELIVER goes to TAKE_A on `rd_ack`, or to ENDBLK if the end of the record is pending.
- COMPARE goes to TAKE_A on a memory handshake, or to ENDBLK if the end of the record is pending.
- ENDBLK goes to IDLE.

Top module: `tape_frame_codec`

## Requirements
- R1: After reset, `busy`, `end_of_block`, `mem_ready`, `tx_frame_valid`, `rx_frame_ready`, `rd_strobe` and `chk_err` are all 0.
- R2: In write mode (0), each memory word taken on `mem_valid && mem_ready` is sent as two frames: bits 7:0 first, then bits 15:8. Each frame is held until `tx_ready`. The next word is taken only after both frames are gone.
- R3: `tx_frame_end` is high with the second frame of the word taken with `mem_last = 1`. After that frame, `end_of_block` is pulsed and the block returns to idle.
- R4: In read forward (1), the first frame of a pair lands in `rd_word` bits 7:0 and the second in bits 15:8.
- R5: In read reverse (2), the first frame of a pair lands in bits 15:8 and the second in bits 7:0.
- R6: `rd_strobe` stays high with `rd_word` stable until `rd_ack`. It is low for at least one cycle before the next word. `rx_frame_ready` is low while the strobe is high.
- R7: An `rx_gap` taken while waiting for the first frame of a pair ends the record without any further word.
- R8: An `rx_gap` taken while waiting for the second frame delivers the partial word with the missing byte zero. That is the high byte when forward and the low byte when reverse. The record then ends.
- R9: In check forward (3) and check reverse (4), each tape word, assembled in the order of R4 or R5, is compared with one memory word taken through `mem_valid`/`mem_ready`. Any differing bit sets `chk_err`. `rd_strobe` never rises in these modes.
- R10: `chk_err` stays set until the next accepted `cmd_start`, which clears it.
- R11: `cmd_start` is ignored while `busy` is high, and it is also ignored with a mode code of 5, 6 or 7.
- R12: `end_of_block` is a one-cycle pulse. `busy` is high from the cycle after an accepted start through the `end_of_block` cycle, and low in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start | input | 1 | Command start pulse |
| cmd_mode | input | 3 | Command mode code |
| busy | output | 1 | Command in progress |
| end_of_block | output | 1 | One-cycle end-of-record pulse |
| mem_word | input | 16 | Memory word (write source or check reference) |
| mem_last | input | 1 | Marks the final write word |
| mem_valid | input | 1 | Memory word valid |
| mem_ready | output | 1 | Block takes the memory word |
| tx_frame | output | 8 | Frame to tape |
| tx_frame_end | output | 1 | Final frame of the record |
| tx_frame_valid | output | 1 | Frame to tape valid |
| tx_ready | input | 1 | Tape accepts the frame |
| rx_frame | input | 8 | Frame from tape |
| rx_frame_valid | input | 1 | Frame from tape valid |
| rx_gap | input | 1 | Inter-record gap seen |
| rx_frame_ready | output | 1 | Block takes a frame or gap |
| rd_word | output | 16 | Assembled read word |
| rd_strobe | output | 1 | Read word transfer strobe |
| rd_ack | input | 1 | Memory side takes the read word |
| chk_err | output | 1 | Sticky write-check mismatch |

## Verification
Reads are fed with even and odd frame counts, with an empty record, and with both directions. Odd counts separate correct zero fill from a stale byte. Reversed order exposes a lane swap that forward data alone would hide. Checks are run with a clean record and with a single flipped bit in one memory word. That shows whether a one-bit difference is caught and whether a clean compare leaves the flag clear. Random handshake stalls on every interface, plus start pulses issued mid-command and with unused modes, separate correct holding and ignoring from dropped or repeated frames and words.

// File: rtl/tfc_pkg.sv
`timescale 1ns/1ps
package tfc_pkg;

    typedef enum logic [2:0] {
        MODE_WRITE  = 3'd0,
        MODE_RD_FWD = 3'd1,
        MODE_RD_REV = 3'd2,
        MODE_CK_FWD = 3'd3,
        MODE_CK_REV = 3'd4
    } tfc_mode_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_FETCH,
        ST_EMIT_LO,
        ST_EMIT_HI,
        ST_TAKE_A,
        ST_TAKE_B,
        ST_DELIVER,
        ST_COMPARE,
        ST_ENDBLK
    } tfc_state_e;

    function automatic logic mode_known(input logic [2:0] m);
        return (m <= 3'd4);
    endfunction

    function automatic logic mode_reverse(input logic [2:0] m);
        return (m == MODE_RD_REV) || (m == MODE_CK_REV);
    endfunction

    function automatic logic mode_check(input logic [2:0] m);
        return (m == MODE_CK_FWD) || (m == MODE_CK_REV);
    endfunction

endpackage

// File: rtl/tfc_fsm.sv
`timescale 1ns/1ps
module tfc_fsm
    import tfc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_start,
    input  logic [2:0] cmd_mode,
    input  logic       mem_valid,
    input  logic       mem_last,
    input  logic       tx_ready,
    input  logic       rx_frame_valid,
    input  logic       rx_gap,
    input  logic       rd_ack,
    output logic       busy,
    output logic       end_of_block,
    output logic       mem_ready,
    output logic       tx_frame_valid,
    output logic       tx_sel_hi,
    output logic       tx_frame_end,
    output logic       rx_frame_ready,
    output logic       rd_strobe,
    output logic       reverse,
    output logic       cmd_go,
    output logic       word_load,
    output logic       take_first,
    output logic       take_second,
    output logic       cmp_fire
);

    tfc_state_e state_q, state_d;
    logic [2:0] mode_q;
    logic       last_q;
    logic       end_pend_q;
    logic       is_check;

    assign is_check = mode_check(mode_q);
    assign reverse  = mode_reverse(mode_q);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // command context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q     <= MODE_WRITE;
            last_q     <= 1'b0;
            end_pend_q <= 1'b0;
        end else begin
            if (cmd_go) begin
                mode_q     <= cmd_mode;
                end_pend_q <= 1'b0;
            end
            if (word_load) begin
                last_q <= mem_last;
            end
            if (state_q == ST_TAKE_B && rx_gap) begin
                end_pend_q <= 1'b1;
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_start && mode_known(cmd_mode)) begin
                    state_d = (cmd_mode == MODE_WRITE) ? ST_FETCH : ST_TAKE_A;
                end
            end
            ST_FETCH:   if (mem_valid) state_d = ST_EMIT_LO;
            ST_EMIT_LO: if (tx_ready)  state_d = ST_EMIT_HI;
            ST_EMIT_HI: if (tx_ready)  state_d = last_q ? ST_ENDBLK : ST_FETCH;
            ST_TAKE_A: begin
                if (rx_gap)              state_d = ST_ENDBLK;
                else if (rx_frame_valid) state_d = ST_TAKE_B;
            end
            ST_TAKE_B: begin
                if (rx_gap || rx_frame_valid) begin
                    state_d = is_check ? ST_COMPARE : ST_DELIVER;
                end
            end
            ST_DELIVER: if (rd_ack)    state_d = end_pend_q ? ST_ENDBLK : ST_TAKE_A;
            ST_COMPARE: if (mem_valid) state_d = end_pend_q ? ST_ENDBLK : ST_TAKE_A;
            ST_ENDBLK:  state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy           = (state_q != ST_IDLE);
        end_of_block   = (state_q == ST_ENDBLK);
        mem_ready      = (state_q == ST_FETCH) || (state_q == ST_COMPARE);
        tx_frame_valid = (state_q == ST_EMIT_LO) || (state_q == ST_EMIT_HI);
        tx_sel_hi      = (state_q == ST_EMIT_HI);
        tx_frame_end   = (state_q == ST_EMIT_HI) && last_q;
        rx_frame_ready = (state_q == ST_TAKE_A) || (state_q == ST_TAKE_B);
        rd_strobe      = (state_q == ST_DELIVER);
        cmd_go         = (state_q == ST_IDLE) && cmd_start && mode_known(cmd_mode);
        word_load      = (state_q == ST_FETCH) && mem_valid;
        take_first     = (state_q == ST_TAKE_A) && rx_frame_valid && !rx_gap;
        take_second    = (state_q == ST_TAKE_B) && rx_frame_valid && !rx_gap;
        cmp_fire       = (state_q == ST_COMPARE) && mem_valid;
    end

endmodule

// File: rtl/tfc_splitter.sv
`timescale 1ns/1ps
module tfc_splitter #(
    parameter int FRAME_W = 8,
    localparam int WORD_W = 2 * FRAME_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [WORD_W-1:0]  word_i,
    input  logic               sel_hi,
    output logic [FRAME_W-1:0] frame_o
);

    logic [WORD_W-1:0] hold_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (load) begin
            hold_q <= word_i;
        end
    end

    assign frame_o = sel_hi ? hold_q[WORD_W-1 -: FRAME_W] : hold_q[FRAME_W-1:0];

endmodule

// File: rtl/tfc_assembler.sv
`timescale 1ns/1ps
module tfc_assembler #(
    parameter int FRAME_W = 8,
    localparam int LANES  = 2,
    localparam int WORD_W = LANES * FRAME_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               take_first,
    input  logic               take_second,
    input  logic               reverse,
    input  logic [FRAME_W-1:0] frame_i,
    output logic [WORD_W-1:0]  word_o
);

    // lane that receives the first frame of a pair; the other lane is
    // cleared at that point so a missing second frame reads as zero
    logic first_lane;
    assign first_lane = reverse;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [FRAME_W-1:0] lane_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lane_q <= '0;
            end else if (take_first) begin
                lane_q <= (first_lane == 1'(l)) ? frame_i : '0;
            end else if (take_second && (first_lane != 1'(l))) begin
                lane_q <= frame_i;
            end
        end
        assign word_o[l*FRAME_W +: FRAME_W] = lane_q;
    end

endmodule

// File: rtl/tfc_compare.sv
`timescale 1ns/1ps
module tfc_compare #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              fire,
    input  logic [WORD_W-1:0] tape_word,
    input  logic [WORD_W-1:0] mem_word,
    output logic              err_o
);

    logic [WORD_W-1:0] diff;
    assign diff = tape_word ^ mem_word;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_o <= 1'b0;
        end else if (clear) begin
            err_o <= 1'b0;
        end else if (fire && (|diff)) begin
            err_o <= 1'b1;
        end
    end

endmodule

// File: rtl/tape_frame_codec.sv
`timescale 1ns/1ps
module tape_frame_codec #(
    parameter int FRAME_W = 8,
    localparam int WORD_W = 2 * FRAME_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_start,
    input  logic [2:0]         cmd_mode,
    output logic               busy,
    output logic               end_of_block,
    input  logic [WORD_W-1:0]  mem_word,
    input  logic               mem_last,
    input  logic               mem_valid,
    output logic               mem_ready,
    output logic [FRAME_W-1:0] tx_frame,
    output logic               tx_frame_end,
    output logic               tx_frame_valid,
    input  logic               tx_ready,
    input  logic [FRAME_W-1:0] rx_frame,
    input  logic               rx_frame_valid,
    input  logic               rx_gap,
    output logic               rx_frame_ready,
    output logic [WORD_W-1:0]  rd_word,
    output logic               rd_strobe,
    input  logic               rd_ack,
    output logic               chk_err
);

    logic tx_sel_hi;
    logic reverse;
    logic cmd_go;
    logic word_load;
    logic take_first;
    logic take_second;
    logic cmp_fire;

    tfc_fsm u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .cmd_start      (cmd_start),
        .cmd_mode       (cmd_mode),
        .mem_valid      (mem_valid),
        .mem_last       (mem_last),
        .tx_ready       (tx_ready),
        .rx_frame_valid (rx_frame_valid),
        .rx_gap         (rx_gap),
        .rd_ack         (rd_ack),
        .busy           (busy),
        .end_of_block   (end_of_block),
        .mem_ready      (mem_ready),
        .tx_frame_valid (tx_frame_valid),
        .tx_sel_hi      (tx_sel_hi),
        .tx_frame_end   (tx_frame_end),
        .rx_frame_ready (rx_frame_ready),
        .rd_strobe      (rd_strobe),
        .reverse        (reverse),
        .cmd_go         (cmd_go),
        .word_load      (word_load),
        .take_first     (take_first),
        .take_second    (take_second),
        .cmp_fire       (cmp_fire)
    );

    tfc_splitter #(.FRAME_W(FRAME_W)) u_split (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (word_load),
        .word_i  (mem_word),
        .sel_hi  (tx_sel_hi),
        .frame_o (tx_frame)
    );

    tfc_assembler #(.FRAME_W(FRAME_W)) u_asm (
        .clk         (clk),
        .rst_n       (rst_n),
        .take_first  (take_first),
        .take_second (take_second),
        .reverse     (reverse),
        .frame_i     (rx_frame),
        .word_o      (rd_word)
    );

    tfc_compare #(.WORD_W(WORD_W)) u_cmp (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (cmd_go),
        .fire      (cmp_fire),
        .tape_word (rd_word),
        .mem_word  (mem_word),
        .err_o     (chk_err)
    );

endmodule

// File: rtl/tfc_checker.sv
`timescale 1ns/1ps
module tfc_checker #(
    parameter int FRAME_W = 8,
    localparam int WORD_W = 2 * FRAME_W
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cmd_start,
    input logic               busy,
    input logic               end_of_block,
    input logic               mem_ready,
    input logic [FRAME_W-1:0] tx_frame,
    input logic               tx_frame_valid,
    input logic               tx_ready,
    input logic               rx_frame_ready,
    input logic [WORD_W-1:0]  rd_word,
    input logic               rd_strobe,
    input logic               rd_ack,
    input logic               chk_err
);

    // R6
    strobe_negate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe && rd_ack |=> !rd_strobe);

    // R6
    strobe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe && !rd_ack |=> rd_strobe && $stable(rd_word));

    // R6
    no_take_in_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe |-> !rx_frame_ready);

    // R2
    frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_frame_valid && !tx_ready |=> tx_frame_valid && $stable(tx_frame));

    // R2
    one_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_ready, tx_frame_valid, rx_frame_ready, rd_strobe}));

    // R12
    eob_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        end_of_block |=> !end_of_block && !busy);

    // R10
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chk_err && !cmd_start |=> chk_err);

endmodule

bind tape_frame_codec tfc_checker #(.FRAME_W(FRAME_W)) u_tfc_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .cmd_start      (cmd_start),
    .busy           (busy),
    .end_of_block   (end_of_block),
    .mem_ready      (mem_ready),
    .tx_frame       (tx_frame),
    .tx_frame_valid (tx_frame_valid),
    .tx_ready       (tx_ready),
    .rx_frame_ready (rx_frame_ready),
    .rd_word        (rd_word),
    .rd_strobe      (rd_strobe),
    .rd_ack         (rd_ack),
    .chk_err        (chk_err)
);

// File: tb/tape_frame_codec_bench.sv
`timescale 1ns/1ps
module tape_frame_codec_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_start = 1'b0;
    logic [2:0]  cmd_mode = 3'd0;
    logic        busy, end_of_block;
    logic [15:0] mem_word = '0;
    logic        mem_last = 1'b0;
    logic        mem_valid = 1'b0;
    logic        mem_ready;
    logic [7:0]  tx_frame;
    logic        tx_frame_end, tx_frame_valid;
    logic        tx_ready = 1'b0;
    logic [7:0]  rx_frame = '0;
    logic        rx_frame_valid = 1'b0;
    logic        rx_gap = 1'b0;
    logic        rx_frame_ready;
    logic [15:0] rd_word;
    logic        rd_strobe;
    logic        rd_ack = 1'b0;
    logic        chk_err;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    tape_frame_codec u_tape_frame_codec (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_mode(cmd_mode),
        .busy(busy), .end_of_block(end_of_block),
        .mem_word(mem_word), .mem_last(mem_last), .mem_valid(mem_valid), .mem_ready(mem_ready),
        .tx_frame(tx_frame), .tx_frame_end(tx_frame_end), .tx_frame_valid(tx_frame_valid),
        .tx_ready(tx_ready),
        .rx_frame(rx_frame), .rx_frame_valid(rx_frame_valid), .rx_gap(rx_gap),
        .rx_frame_ready(rx_frame_ready),
        .rd_word(rd_word), .rd_strobe(rd_strobe), .rd_ack(rd_ack), .chk_err(chk_err)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic quiet_inputs();
        cmd_start = 1'b0; mem_valid = 1'b0; mem_last = 1'b0; tx_ready = 1'b0;
        rx_frame_valid = 1'b0; rx_gap = 1'b0; rd_ack = 1'b0;
    endtask

    task automatic start_cmd(input logic [2:0] m);
        @(negedge clk);
        cmd_start = 1'b1;
        cmd_mode  = m;
        @(negedge clk);
        cmd_start = 1'b0;
    endtask

    function automatic logic [15:0] pack_word(input logic [7:0] first, input logic [7:0] second,
                                              input bit rev);
        return rev ? {first, second} : {second, first};
    endfunction

    // checks the end of a command: R12 pulse then idle
    task automatic finish_cmd(input string req);
        check(busy == 1'b1, "R12", {req, " busy in eob cycle"}, busy, 1);
        quiet_inputs();
        @(negedge clk);
        check(!busy && !end_of_block, "R12", {req, " idle after eob"}, {busy, end_of_block}, 0);
    endtask

    // write command: R2, R3, R11 (stray starts while busy)
    task automatic run_write(input int nw, input bit stray);
        logic [15:0] words[32];
        int wi, fi, cyc;
        bit done;
        for (int i = 0; i < nw; i++) words[i] = 16'($urandom);
        start_cmd(3'd0);
        wi = 0; fi = 0; cyc = 0; done = 0;
        while (!done) begin
            if (end_of_block) begin
                check(fi == 2 * nw, "R3", "frame count at eob", fi, 2 * nw);
                finish_cmd("R3");
                done = 1;
            end else begin
                cmd_start = stray && ($urandom % 5 == 0);
                cmd_mode  = 3'd1;
                mem_valid = (wi < nw) && ($urandom % 4 != 0);
                mem_word  = (wi < nw) ? words[wi] : 16'hDEAD;
                mem_last  = (wi == nw - 1);
                if (mem_valid && mem_ready) wi++;
                tx_ready = ($urandom % 3 != 0);
                if (tx_frame_valid && tx_ready) begin
                    if (fi < 2 * nw) begin
                        check(tx_frame == ((fi % 2) ? words[fi/2][15:8] : words[fi/2][7:0]),
                              stray ? "R11" : "R2", "tx frame", tx_frame,
                              (fi % 2) ? words[fi/2][15:8] : words[fi/2][7:0]);
                        check(tx_frame_end == (fi == 2 * nw - 1), "R3", "frame end flag",
                              tx_frame_end, fi == 2 * nw - 1);
                    end else begin
                        check(0, "R2", "extra frame", fi, 2 * nw);
                    end
                    fi++;
                end
                cyc++;
                if (cyc > 4000) begin
                    check(0, "R3", "write timeout", cyc, 0);
                    done = 1;
                end
                @(negedge clk);
            end
        end
    endtask

    // read or check command: R4..R9
    task automatic run_rx(input logic [2:0] m, input int nf, input int bad);
        logic [7:0]  fr[64];
        logic [15:0] ew[32];
        int nw, fi, wi, mi, cyc;
        bit rev, ck, gap_sent, done, exp_err;
        string rq;
        rev = (m == 3'd2) || (m == 3'd4);
        ck  = (m == 3'd3) || (m == 3'd4);
        nw  = (nf + 1) / 2;
        rq  = ck ? "R9" : (nf % 2 ? "R8" : (rev ? "R5" : "R4"));
        for (int i = 0; i < nf; i++) fr[i] = 8'($urandom);
        for (int i = 0; i < nw; i++)
            ew[i] = pack_word(fr[2*i], (2*i+1 < nf) ? fr[2*i+1] : 8'h00, rev);
        exp_err = ck && (bad >= 0) && (bad < nw);
        start_cmd(m);
        fi = 0; wi = 0; mi = 0; cyc = 0; gap_sent = 0; done = 0;
        while (!done) begin
            if (end_of_block) begin
                check((ck ? mi : wi) == nw, "R7", "words at eob", ck ? mi : wi, nw);
                if (ck) check(chk_err == exp_err, "R9", "check error flag", chk_err, exp_err);
                finish_cmd("R7");
                done = 1;
            end else begin
                rx_gap = 1'b0;
                rx_frame_valid = 1'b0;
                if (fi < nf) begin
                    rx_frame_valid = ($urandom % 4 != 0);
                    rx_frame = fr[fi];
                    if (rx_frame_valid && rx_frame_ready) fi++;
                end else if (!gap_sent && rx_frame_ready) begin
                    rx_gap = 1'b1;
                    gap_sent = 1;
                end
                rd_ack = ($urandom % 3 != 0);
                if (rd_strobe) begin
                    if (ck) check(0, "R9", "strobe in check mode", 1, 0);
                    else if (rd_ack) begin
                        if (wi < nw)
                            check(rd_word == ew[wi], rq, "read word", rd_word, ew[wi]);
                        else
                            check(0, "R7", "extra read word", wi, nw);
                        wi++;
                    end
                end
                mem_valid = 1'b0;
                if (ck && mi < nw) begin
                    mem_valid = ($urandom % 3 != 0);
                    mem_word  = ew[mi] ^ ((mi == bad) ? (16'd1 << ($urandom % 16)) : 16'd0);
                    if (mem_valid && mem_ready) mi++;
                end
                cyc++;
                if (cyc > 4000) begin
                    check(0, rq, "read timeout", cyc, 0);
                    done = 1;
                end
                @(negedge clk);
            end
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1 reset state
        check({busy, end_of_block, mem_ready, tx_frame_valid, rx_frame_ready, rd_strobe, chk_err} == 0,
              "R1", "outputs in reset", {busy, end_of_block, mem_ready, tx_frame_valid,
              rx_frame_ready, rd_strobe, chk_err}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check({busy, mem_ready, rx_frame_ready, chk_err} == 0, "R1", "outputs after reset",
              {busy, mem_ready, rx_frame_ready, chk_err}, 0);

        // R11 unused mode codes are ignored
        for (int m = 5; m < 8; m++) begin
            start_cmd(3'(m));
            check(!busy && !mem_ready && !rx_frame_ready, "R11", "unused mode ignored", busy, 0);
        end

        run_write(1, 0);           // R2 R3 single word
        run_write(5, 1);           // R11 stray starts while busy
        run_rx(3'd1, 6, -1);       // R4 even forward
        run_rx(3'd2, 6, -1);       // R5 even reverse
        run_rx(3'd1, 3, -1);       // R8 odd forward, high byte zero
        run_rx(3'd2, 5, -1);       // R8 odd reverse, low byte zero
        run_rx(3'd1, 0, -1);       // R7 empty record
        run_rx(3'd3, 8, -1);       // R9 clean check forward
        run_rx(3'd4, 7, 2);        // R9 bad word in check reverse

        // R10 flag sticky while idle, cleared by next start
        repeat (4) @(negedge clk);
        check(chk_err == 1'b1, "R10", "error held while idle", chk_err, 1);
        start_cmd(3'd0);
        check(chk_err == 1'b0, "R10", "error cleared by start", chk_err, 0);
        mem_valid = 1'b1; mem_last = 1'b1; mem_word = 16'h5AA5; tx_ready = 1'b1;
        while (!end_of_block) @(negedge clk);
        quiet_inputs();
        @(negedge clk);

        // random mix
        for (int it = 0; it < 24; it++) begin
            int m;
            m = $urandom % 5;
            if (m == 0) run_write(1 + $urandom % 6, $urandom % 2);
            else run_rx(3'(m), $urandom % 12, ($urandom % 2) ? int'($urandom % 6) : -1);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog run did not finish actual=%0d expected=%0d", 150000, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule